// File: doc/BRIEF.md
# Per-Timeslot Transmit Code Substitution

This block sits in the transmit path of a T1/E1 framer, between the backplane byte stream and the framing logic. Each cycle with `in_valid` high carries one channel byte, its timeslot index (0-based, so channel c arrives on index c-1) and the line mode. For each timeslot the block may overwrite the byte with a programmable idle code. If the incoming byte is all zeros, it may instead replace the byte with a DDS zero code (T1 only) or with a jammed-bit-eight stuffing code. Both of these zero-byte substitutions are gated by a global enable as well as by a per-channel bitmap bit.

A byte-wide write port loads the configuration. This covers three per-channel enable bitmaps, a 32-entry idle code array, the two stuffing codes and a control byte holding the two global enables. The result leaves on a registered output one clock later, with the timeslot index and a valid strobe travelling alongside.

Top module: `tsub_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data`/`out_ts` are 0. All enable bitmaps and the control byte reset to 0, so every byte passes through unchanged until the block is configured.
- R2: A byte presented with `in_valid` high appears on `out_data` one clock later, with `out_valid` high and `out_ts` equal to its index. A cycle with `in_valid` low gives `out_valid` low one clock later, and `out_data` keeps its previous value.
- R3: Register map (6-bit byte address). Idle codes for index i are at 0x00+i (i = 0..31). The idle-enable bitmap is at 0x20..0x23, the jam-enable bitmap at 0x24..0x27 and the DDS-enable bitmap at 0x28..0x2A. The jam code is at 0x2C, the DDS code at 0x2D, and the control byte at 0x2E (bit 0 = jam global enable, bit 1 = DDS global enable). In bitmap byte k (0-based), bit b controls timeslot index 8k+b.
- R4: When a timeslot's idle-enable bit is 1, its output byte is that timeslot's idle code, whatever the input byte is.
- R5: When the idle bit is 0, the jam-enable bit is 1, control bit 0 is 1 and the input byte is 0x00, the output is the jam code. A non-zero byte passes through.
- R6: In T1 mode (`mode_e1`=0), for index < 24, with the idle bit 0, the DDS bit 1, control bit 1 set and an input byte of 0x00, the output is the DDS code. In E1 mode the DDS bitmap has no effect.
- R7: Priority, highest first: idle code, DDS code, jam code, pass-through. The all-zero test always uses the incoming byte.
- R8: If a bitmap bit is 0, or the matching global enable is 0, the corresponding substitution leaves the byte unchanged.
- R9: In T1 mode, any index of 24 or more passes through with no substitution of any kind.
- R10: The jam code resets to 0x01, the DDS code to 0x98 and every idle code to 0x7F.
- R11: A write takes effect from the next byte onward: a byte sampled at the same clock edge as a write uses the old setting. Writes to unmapped addresses (0x2B, 0x2F..0x3F) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e1 | input | 1 | 1 = E1 (32 timeslots), 0 = T1 (24 timeslots) |
| in_valid | input | 1 | Input byte strobe |
| in_ts | input | 5 | Timeslot index of the input byte |
| in_data | input | 8 | Channel byte from the backplane |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| out_valid | output | 1 | Output byte strobe |
| out_ts | output | 5 | Timeslot index of the output byte |
| out_data | output | 8 | Substituted channel byte |

## Verification
A wrong bitmap bit, code byte or global enable in the configuration store shows up the first time its timeslot comes through. It appears one clock later on `out_data`, either as the wrong code or as a byte that should have been replaced but passes through. The bench sweeps every timeslot in both modes with zero and non-zero bytes under several bitmap and enable patterns, so any corrupted configuration bit is exposed within one sweep. A faulty priority or zero test is exposed at the first timeslot where two substitutions overlap.

// File: rtl/tsub_pkg.sv
package tsub_pkg;

   typedef enum logic [1:0] {
      SUB_PASS = 2'd0,
      SUB_IDLE = 2'd1,
      SUB_DDS  = 2'd2,
      SUB_JAM  = 2'd3
   } sub_kind_e;

   localparam int ADR_CODE_BASE = 'h00;
   localparam int ADR_IDLE_EN   = 'h20;
   localparam int ADR_JAM_EN    = 'h24;
   localparam int ADR_DDS_EN    = 'h28;
   localparam int ADR_JAM_CODE  = 'h2C;
   localparam int ADR_DDS_CODE  = 'h2D;
   localparam int ADR_CTRL      = 'h2E;

   localparam int CTRL_JAM_BIT  = 0;
   localparam int CTRL_DDS_BIT  = 1;

endpackage

// File: rtl/tsub_regs.sv
module tsub_regs
   import tsub_pkg::*;
#(
   parameter int          NUM_CH   = 32,
   parameter int          T1_CH    = 24,
   parameter int          DW       = 8,
   parameter int          AW       = 6,
   parameter logic [DW-1:0] IDLE_RST = 8'h7F,
   parameter logic [DW-1:0] JAM_RST  = 8'h01,
   parameter logic [DW-1:0] DDS_RST  = 8'h98
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [AW-1:0]            cfg_addr,
   input  logic [DW-1:0]            cfg_wdata,
   output logic [NUM_CH-1:0]        idle_en,
   output logic [NUM_CH-1:0]        jam_en,
   output logic [T1_CH-1:0]         dds_en,
   output logic [NUM_CH-1:0][DW-1:0] idle_code,
   output logic [DW-1:0]            jam_code,
   output logic [DW-1:0]            dds_code,
   output logic                     jam_on,
   output logic                     dds_on
);

   localparam int EN_BYTES  = NUM_CH / 8;
   localparam int DDS_BYTES = T1_CH / 8;

   if (NUM_CH % 8 != 0 || NUM_CH > 32) begin : g_bad_numch
      $error("tsub_regs: NUM_CH must be a multiple of 8 and at most 32");
   end
   if (T1_CH % 8 != 0 || T1_CH > NUM_CH) begin : g_bad_t1ch
      $error("tsub_regs: T1_CH must be a multiple of 8 and not exceed NUM_CH");
   end
   if (DW < 8) begin : g_bad_dw
      $error("tsub_regs: DW must be at least 8");
   end
   if (AW < 6) begin : g_bad_aw
      $error("tsub_regs: AW must be at least 6");
   end

   for (genvar g = 0; g < EN_BYTES; g++) begin : g_en_byte
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idle_en[g*8 +: 8] <= '0;
            jam_en[g*8 +: 8]  <= '0;
         end else if (cfg_we) begin
            if (cfg_addr == AW'(ADR_IDLE_EN + g))
               idle_en[g*8 +: 8] <= cfg_wdata[7:0];
            if (cfg_addr == AW'(ADR_JAM_EN + g))
               jam_en[g*8 +: 8] <= cfg_wdata[7:0];
         end
      end
   end

   for (genvar g = 0; g < DDS_BYTES; g++) begin : g_dds_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            dds_en[g*8 +: 8] <= '0;
         else if (cfg_we && cfg_addr == AW'(ADR_DDS_EN + g))
            dds_en[g*8 +: 8] <= cfg_wdata[7:0];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_code
      always_ff @(posedge clk) begin
         if (!rst_n)
            idle_code[c] <= IDLE_RST;
         else if (cfg_we && cfg_addr == AW'(ADR_CODE_BASE + c))
            idle_code[c] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         jam_code <= JAM_RST;
         dds_code <= DDS_RST;
         jam_on   <= 1'b0;
         dds_on   <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_addr == AW'(ADR_JAM_CODE)) jam_code <= cfg_wdata;
         if (cfg_addr == AW'(ADR_DDS_CODE)) dds_code <= cfg_wdata;
         if (cfg_addr == AW'(ADR_CTRL)) begin
            jam_on <= cfg_wdata[CTRL_JAM_BIT];
            dds_on <= cfg_wdata[CTRL_DDS_BIT];
         end
      end
   end

endmodule

// File: rtl/tsub_chsel.sv
module tsub_chsel
   import tsub_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int T1_CH   = 24,
   parameter int DW      = 8,
   parameter bit HAS_DDS = 1'b1,
   localparam int TS_W   = $clog2(NUM_CH)
) (
   input  logic                      mode_e1,
   input  logic [TS_W-1:0]           ts,
   input  logic [DW-1:0]             din,
   input  logic [NUM_CH-1:0]         idle_en,
   input  logic [NUM_CH-1:0]         jam_en,
   input  logic [T1_CH-1:0]          dds_en,
   input  logic [NUM_CH-1:0][DW-1:0] idle_code,
   input  logic [DW-1:0]             jam_code,
   input  logic [DW-1:0]             dds_code,
   input  logic                      jam_on,
   input  logic                      dds_on,
   output sub_kind_e                 kind,
   output logic [DW-1:0]             dout
);

   localparam logic [TS_W-1:0] T1_LIM = TS_W'(T1_CH);

   logic zero_byte;
   logic t1_beyond;
   logic dds_hit;
   logic jam_hit;

   assign zero_byte = (din == '0);
   assign t1_beyond = !mode_e1 && (ts >= T1_LIM);
   assign jam_hit   = zero_byte && jam_on && jam_en[ts];

   if (HAS_DDS) begin : g_dds
      assign dds_hit = zero_byte && !mode_e1 && dds_on &&
                       (ts < T1_LIM) && dds_en[ts];
   end else begin : g_no_dds
      assign dds_hit = 1'b0;
   end

   always_comb begin
      kind = SUB_PASS;
      if (!t1_beyond) begin
         if (idle_en[ts])  kind = SUB_IDLE;
         else if (dds_hit) kind = SUB_DDS;
         else if (jam_hit) kind = SUB_JAM;
      end
   end

   always_comb begin
      unique case (kind)
         SUB_IDLE: dout = idle_code[ts];
         SUB_DDS:  dout = dds_code;
         SUB_JAM:  dout = jam_code;
         default:  dout = din;
      endcase
   end

   always_comb begin
      if (kind == SUB_DDS) assert_dds_t1_only_R6: assert (!mode_e1);
      if (kind != SUB_PASS && kind != SUB_IDLE) assert_zero_only_R5: assert (zero_byte);
   end

endmodule

// File: rtl/tsub_top.sv
module tsub_top
   import tsub_pkg::*;
#(
   parameter int          NUM_CH   = 32,
   parameter int          T1_CH    = 24,
   parameter int          DW       = 8,
   parameter int          AW       = 6,
   parameter bit          HAS_DDS  = 1'b1,
   parameter logic [DW-1:0] IDLE_RST = 8'h7F,
   parameter logic [DW-1:0] JAM_RST  = 8'h01,
   parameter logic [DW-1:0] DDS_RST  = 8'h98,
   localparam int         TS_W     = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_e1,
   input  logic            in_valid,
   input  logic [TS_W-1:0] in_ts,
   input  logic [DW-1:0]   in_data,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [DW-1:0]   cfg_wdata,
   output logic            out_valid,
   output logic [TS_W-1:0] out_ts,
   output logic [DW-1:0]   out_data
);

   localparam logic [TS_W-1:0] T1_LIM = TS_W'(T1_CH);

   logic [NUM_CH-1:0]         idle_en;
   logic [NUM_CH-1:0]         jam_en;
   logic [T1_CH-1:0]          dds_en;
   logic [NUM_CH-1:0][DW-1:0] idle_code;
   logic [DW-1:0]             jam_code;
   logic [DW-1:0]             dds_code;
   logic                      jam_on;
   logic                      dds_on;
   sub_kind_e                 kind;
   logic [DW-1:0]             sel_data;

   tsub_regs #(
      .NUM_CH(NUM_CH), .T1_CH(T1_CH), .DW(DW), .AW(AW),
      .IDLE_RST(IDLE_RST), .JAM_RST(JAM_RST), .DDS_RST(DDS_RST)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .idle_en   (idle_en),
      .jam_en    (jam_en),
      .dds_en    (dds_en),
      .idle_code (idle_code),
      .jam_code  (jam_code),
      .dds_code  (dds_code),
      .jam_on    (jam_on),
      .dds_on    (dds_on)
   );

   tsub_chsel #(
      .NUM_CH(NUM_CH), .T1_CH(T1_CH), .DW(DW), .HAS_DDS(HAS_DDS)
   ) chsel_i (
      .mode_e1   (mode_e1),
      .ts        (in_ts),
      .din       (in_data),
      .idle_en   (idle_en),
      .jam_en    (jam_en),
      .dds_en    (dds_en),
      .idle_code (idle_code),
      .jam_code  (jam_code),
      .dds_code  (dds_code),
      .jam_on    (jam_on),
      .dds_on    (dds_on),
      .kind      (kind),
      .dout      (sel_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ts    <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ts   <= in_ts;
            out_data <= sel_data;
         end
      end
   end

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(in_valid));

   assert_ts_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_ts == $past(in_ts));

   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   assert_t1_beyond_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !mode_e1 && in_ts >= T1_LIM |=> out_data == $past(in_data));

   assert_nonzero_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_data != '0 && !idle_en[in_ts] |=> out_data == $past(in_data));

   assert_e1_no_dds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && mode_e1 && in_data == '0 && !idle_en[in_ts] &&
      !(jam_on && jam_en[in_ts]) |=> out_data == '0);

endmodule

// File: tb/tsub_top_tb_top.sv
module tsub_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mode_e1;
   logic       in_valid;
   logic [4:0] in_ts;
   logic [7:0] in_data;
   logic       cfg_we;
   logic [5:0] cfg_addr;
   logic [7:0] cfg_wdata;
   logic       out_valid;
   logic [4:0] out_ts;
   logic [7:0] out_data;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_idle;
   logic [31:0] m_jam;
   logic [23:0] m_dds;
   logic [7:0]  m_code [32];
   logic [7:0]  m_jamc;
   logic [7:0]  m_ddsc;
   logic [1:0]  m_ctrl;

   always #4 clk = ~clk;

   tsub_top dut_i (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .in_valid(in_valid),
      .in_ts(in_ts), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ts(out_ts),
      .out_data(out_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic model_write(input logic [5:0] a, input logic [7:0] d);
      if (a < 6'h20) m_code[a] = d;
      else if (a >= 6'h20 && a <= 6'h23) m_idle[(a - 6'h20) * 8 +: 8] = d;
      else if (a >= 6'h24 && a <= 6'h27) m_jam[(a - 6'h24) * 8 +: 8] = d;
      else if (a >= 6'h28 && a <= 6'h2A) m_dds[(a - 6'h28) * 8 +: 8] = d;
      else if (a == 6'h2C) m_jamc = d;
      else if (a == 6'h2D) m_ddsc = d;
      else if (a == 6'h2E) m_ctrl = d[1:0];
   endtask

   task automatic cfg_write(input logic [5:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(a, d);
   endtask

   task automatic expect_byte(input logic m, input logic [4:0] ts, input logic [7:0] d,
                              output logic [7:0] e, output string tag);
      e = d; tag = "R8";
      if (!m && ts >= 5'd24) tag = "R9";
      else if (m_idle[ts]) begin e = m_code[ts]; tag = "R4"; end
      else if (d == 8'h00 && !m && m_ctrl[1] && m_dds[ts]) begin
         e = m_ddsc; tag = m_jam[ts] && m_ctrl[0] ? "R7" : "R6";
      end
      else if (d == 8'h00 && m_ctrl[0] && m_jam[ts]) begin e = m_jamc; tag = "R5"; end
   endtask

   task automatic send_chk(input logic m, input logic [4:0] ts, input logic [7:0] d);
      logic [7:0] e;
      string tag;
      expect_byte(m, ts, d, e, tag);
      mode_e1 = m; in_valid = 1'b1; in_ts = ts; in_data = d;
      @(negedge clk);
      check({tag, " data"}, {24'h0, out_data}, {24'h0, e});
      check("R2 valid", {31'h0, out_valid}, 32'h1);
      check("R2 ts", {27'h0, out_ts}, {27'h0, ts});
   endtask

   task automatic sweep();
      for (int m = 0; m < 2; m++)
         for (int ts = 0; ts < 32; ts++)
            for (int v = 0; v < 4; v++) begin
               logic [7:0] d;
               case (v)
                  0: d = 8'h00;
                  1: d = 8'h5A;
                  2: d = 8'(ts + 1);
                  default: d = 8'h80;
               endcase
               send_chk(m[0], 5'(ts), d);
            end
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode_e1 = 1'b0; in_valid = 1'b0; in_ts = '0; in_data = '0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      m_idle = '0; m_jam = '0; m_dds = '0; m_jamc = 8'h01; m_ddsc = 8'h98; m_ctrl = '0;
      for (int i = 0; i < 32; i++) m_code[i] = 8'h7F;
      repeat (3) @(negedge clk);
      check("R1 valid", {31'h0, out_valid}, 32'h0);
      check("R1 data", {24'h0, out_data}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", {31'h0, out_valid}, 32'h0);
      check("R1 ts after release", {27'h0, out_ts}, 32'h0);

      // R1: defaults pass everything through
      sweep();

      // R10: reset idle code seen once an enable is set
      cfg_write(6'h20, 8'h01);
      send_chk(1'b1, 5'd0, 8'h42);
      check("R10 idle reset code", {24'h0, out_data}, 32'h7F);
      cfg_write(6'h20, 8'h00);

      for (int k = 0; k < 4; k++) begin
         logic [31:0] iw, jw;
         logic [23:0] dw;
         iw = 32'h1111_1111 << k;
         jw = 32'hFFFF_FFFF >> (k * 3);
         dw = 24'hAAAAAA ^ (24'h000FFF << (k * 4));
         for (int c = 0; c < 32; c++) cfg_write(6'(c), 8'((c * 37 + k * 11 + 3) & 8'hFF));
         for (int b = 0; b < 4; b++) cfg_write(6'(6'h20 + b), iw[b*8 +: 8]);
         for (int b = 0; b < 4; b++) cfg_write(6'(6'h24 + b), jw[b*8 +: 8]);
         for (int b = 0; b < 3; b++) cfg_write(6'(6'h28 + b), dw[b*8 +: 8]);
         if (k >= 2) begin
            cfg_write(6'h2C, 8'(8'hC3 + k));
            cfg_write(6'h2D, 8'(8'h3C + k));
         end
         cfg_write(6'h2E, 8'((k + 3) % 4));
         // R3 R5 R6 R7 R8 R9 R10 in the sweep (k=0 uses reset stuffing codes)
         sweep();
      end

      // R11: unmapped writes change nothing
      cfg_write(6'h2B, 8'hFF);
      cfg_write(6'h2F, 8'hFF);
      cfg_write(6'h3F, 8'h00);
      cfg_write(6'h35, 8'h55);
      sweep();

      // R11: write in the same cycle as a byte uses the old value
      cfg_write(6'h20, 8'h00);
      cfg_we = 1'b1; cfg_addr = 6'h20; cfg_wdata = 8'h08;
      mode_e1 = 1'b1; in_valid = 1'b1; in_ts = 5'd3; in_data = 8'h33;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R11 same-edge old value", {24'h0, out_data}, 32'h33);
      model_write(6'h20, 8'h08);
      send_chk(1'b1, 5'd3, 8'h33);
      check("R11 next byte new value", {24'h0, out_data}, {24'h0, m_code[3]});

      // R2: in_valid low holds data and drops out_valid
      in_valid = 1'b0; in_data = 8'hEE; in_ts = 5'd9;
      @(negedge clk);
      check("R2 valid low", {31'h0, out_valid}, 32'h0);
      check("R2 data held", {24'h0, out_data}, {24'h0, m_code[3]});
      check("R2 ts held", {27'h0, out_ts}, 32'd3);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule